// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Receiver

This block receives asynchronous serial frames from a single line and presents each completed character in a holding register for a host to read. The line is watched with a 16x bit-rate tick that comes from outside the block. The middle of every bit is sampled on three neighbouring ticks, and the bit takes the value held by at least two of the three samples, so a short noise pulse near the centre does not change it. A falling edge that is not still low at the centre of the start bit is dropped as noise, and the receiver goes back to waiting for a new edge.

There are two frame lengths. A short frame carries eight data bits and a long frame carries nine. In the long frame the ninth bit can act as an address marker for links with several nodes: when address filtering is on, only frames whose ninth bit is set are passed on. The block has two storage stages. A finished frame moves into a holding register, so the next frame can shift in while the host has not yet read the previous one. If a frame finishes while the holding register is still unread, the unread data is kept and an overrun flag is raised.

Top module: `uart_vote_rx`

## Requirements
- R1: After reset, `rx_ready`, `rx_overrun`, `rx_bit9` and `rx_byte` are all 0.
- R2: With `nine_bit_mode`=0 the frame is one low start bit, 8 data bits sent least significant bit first, and one high stop bit. After a valid frame, `rx_byte` holds the data, `rx_bit9` is 0 and `rx_ready` is 1.
- R3: With `nine_bit_mode`=1 the frame is one start bit, 9 data bits sent least significant bit first, and one stop bit. The first 8 data bits appear on `rx_byte` and the ninth appears on `rx_bit9`.
- R4: Each bit is taken on the 7th, 8th and 9th ticks after the bit begins, and its value is the majority of those three samples. An inversion of the line lasting one tick inside a bit, including the start bit, does not change the received value.
- R5: If the start bit does not vote low at its centre, reception is abandoned with no effect on the outputs, and a valid frame that follows is received correctly.
- R6: A frame whose stop bit votes low is discarded: `rx_ready`, `rx_byte` and `rx_bit9` are unchanged.
- R7: With `nine_bit_mode`=1 and `addr_filter_en`=1, a frame whose ninth bit is 0 is discarded and a frame whose ninth bit is 1 is accepted. Both mode inputs are captured when the start edge is detected.
- R8: A new frame can be received while the holding register is full. If the host reads during that frame, the new frame is loaded when it completes, with no overrun.
- R9: If a frame completes while `rx_ready` is 1 and there is no read in that cycle, `rx_overrun` becomes 1 and `rx_byte`/`rx_bit9` keep the old data.
- R10: A one-cycle `rd_strobe` clears `rx_ready` and `rx_overrun` in the next cycle, unless a frame is loaded in the same cycle, in which case `rx_ready` stays 1 with the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd_in | input | 1 | Serial line, idle high, asynchronous |
| tick_16x | input | 1 | One-cycle pulse at 16 times the bit rate |
| nine_bit_mode | input | 1 | 0: eight data bits, 1: nine data bits |
| addr_filter_en | input | 1 | Accept only frames with ninth bit 1 (nine-bit mode) |
| rd_strobe | input | 1 | Host read pulse, clears ready and overrun |
| rx_byte | output | 8 | Received data byte |
| rx_bit9 | output | 1 | Received ninth bit (0 in eight-bit mode) |
| rx_ready | output | 1 | Holding register contains unread data |
| rx_overrun | output | 1 | A frame arrived while the holding register was full |

## Verification
The bench uses the default parameters: 16 ticks per bit, 8 data bits and a two-stage synchronizer. It drives a tick every fourth clock, so one bit lasts 64 clocks and a few dozen frames of either length fit easily in the run. With this tick spacing, a line inversion lasting four clocks covers exactly one sampling tick. This lets the bench place single-sample noise inside the three-sample window and shorten a start pulse so that it ends before the window. Stop-bit failures, address filtering, reads that overlap a frame and overruns are each exercised directly. Random frames in both lengths are also compared against a model computed in the bench.

// File: rtl/uvr_pkg.sv
package uvr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/uvr_sync.sv
module uvr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uvr_vote.sv
module uvr_vote #(
  parameter int OVERSAMPLE = 16,
  localparam int PH_W = $clog2(OVERSAMPLE),
  localparam int MID  = OVERSAMPLE / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            active,
  input  logic [PH_W-1:0] phase,
  input  logic            line,
  output logic            vote_valid,
  output logic            vote_bit
);
  localparam logic [PH_W-1:0] PH_A = PH_W'(MID - 1);
  localparam logic [PH_W-1:0] PH_B = PH_W'(MID);
  localparam logic [PH_W-1:0] PH_C = PH_W'(MID + 1);

  logic samp_a, samp_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_a <= 1'b1;
      samp_b <= 1'b1;
    end else if (tick && active) begin
      if (phase == PH_A) samp_a <= line;
      if (phase == PH_B) samp_b <= line;
    end
  end

  assign vote_valid = tick && active && (phase == PH_C);
  assign vote_bit   = (samp_a & samp_b) | (samp_a & line) | (samp_b & line);

  // R4: two agreeing stored samples decide the bit whatever the third one is
  assert_two_agree_R4: assert property (@(posedge clk) disable iff (rst)
    (vote_valid && (samp_a == samp_b)) |-> (vote_bit == samp_a));
endmodule

// File: rtl/uvr_frame.sv
module uvr_frame
  import uvr_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8,
  localparam int PH_W = $clog2(OVERSAMPLE),
  localparam int NB   = DATA_W + 1,
  localparam int BC_W = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  input  logic              nine_bit_mode,
  input  logic              addr_filter_en,
  output logic              frame_ok,
  output logic [DATA_W-1:0] frame_byte,
  output logic              frame_bit9
);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(OVERSAMPLE - 1);
  localparam logic [BC_W-1:0] LAST_LONG  = BC_W'(NB - 1);
  localparam logic [BC_W-1:0] LAST_SHORT = BC_W'(NB - 2);

  rx_state_t       state;
  logic [PH_W-1:0] phase;
  logic [BC_W-1:0] bit_cnt;
  logic [NB-1:0]   shreg;
  logic            mode_long, mode_filt;
  logic            vote_valid, vote_bit;
  logic [BC_W-1:0] last_bit;

  uvr_vote #(.OVERSAMPLE(OVERSAMPLE)) vote_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .active     (state != ST_IDLE),
    .phase      (phase),
    .line       (line),
    .vote_valid (vote_valid),
    .vote_bit   (vote_bit)
  );

  assign last_bit = mode_long ? LAST_LONG : LAST_SHORT;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      phase     <= '0;
      bit_cnt   <= '0;
      shreg     <= '0;
      mode_long <= 1'b0;
      mode_filt <= 1'b0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          if (!line) begin
            state     <= ST_START;
            phase     <= PH_W'(1);
            mode_long <= nine_bit_mode;
            mode_filt <= addr_filter_en;
          end
        end
        ST_START: begin
          if (vote_valid && vote_bit) begin
            state <= ST_IDLE;
            phase <= '0;
          end else if (phase == PH_LAST) begin
            state   <= ST_DATA;
            phase   <= '0;
            bit_cnt <= '0;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_DATA: begin
          if (vote_valid) shreg <= {vote_bit, shreg[NB-1:1]};
          if (phase == PH_LAST) begin
            phase <= '0;
            if (bit_cnt == last_bit) state <= ST_STOP;
            else bit_cnt <= bit_cnt + 1'b1;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_STOP: begin
          if (vote_valid) begin
            state <= ST_IDLE;
            phase <= '0;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign frame_byte = mode_long ? shreg[DATA_W-1:0] : shreg[DATA_W:1];
  assign frame_bit9 = mode_long & shreg[DATA_W];
  assign frame_ok   = (state == ST_STOP) && vote_valid && vote_bit &&
                      !(mode_long && mode_filt && !shreg[DATA_W]);

  // R5: a start bit that votes high sends the receiver back to idle
  assert_false_start_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && vote_valid && vote_bit) |=> (state == ST_IDLE));
  // R2: a completed frame always leaves the receiver idle
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
    frame_ok |=> (state == ST_IDLE));
endmodule

// File: rtl/uvr_hold.sv
module uvr_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              din9,
  input  logic              rd,
  output logic [DATA_W-1:0] dout,
  output logic              dout9,
  output logic              ready,
  output logic              overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout9   <= 1'b0;
      ready   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (rd) begin
        ready   <= 1'b0;
        overrun <= 1'b0;
      end
      if (load) begin
        if (!ready || rd) begin
          dout  <= din;
          dout9 <= din9;
          ready <= 1'b1;
        end else begin
          overrun <= 1'b1;
        end
      end
    end
  end

  // R10: a read with no load in the same cycle empties the holding register
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (rd && !load) |=> (!ready && !overrun));
  // R9: a frame arriving on a full register keeps the old data and flags it
  assert_overrun_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (load && ready && !rd) |=> (overrun && $stable(dout) && $stable(dout9)));
  // R9: the overrun flag only rises while data was waiting
  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(ready));
endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx #(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd_in,
  input  logic              tick_16x,
  input  logic              nine_bit_mode,
  input  logic              addr_filter_en,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_bit9,
  output logic              rx_ready,
  output logic              rx_overrun
);
  logic              line_s;
  logic              frame_ok;
  logic [DATA_W-1:0] frame_byte;
  logic              frame_bit9;

  uvr_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd_in),
    .dout (line_s)
  );

  uvr_frame #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) frame_i (
    .clk            (clk),
    .rst            (rst),
    .tick           (tick_16x),
    .line           (line_s),
    .nine_bit_mode  (nine_bit_mode),
    .addr_filter_en (addr_filter_en),
    .frame_ok       (frame_ok),
    .frame_byte     (frame_byte),
    .frame_bit9     (frame_bit9)
  );

  uvr_hold #(.DATA_W(DATA_W)) hold_i (
    .clk     (clk),
    .rst     (rst),
    .load    (frame_ok),
    .din     (frame_byte),
    .din9    (frame_bit9),
    .rd      (rd_strobe),
    .dout    (rx_byte),
    .dout9   (rx_bit9),
    .ready   (rx_ready),
    .overrun (rx_overrun)
  );
endmodule

// File: tb/uart_vote_rx_tb_top.sv
module uart_vote_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd_in = 1'b1;
  logic       tick_16x = 1'b0;
  logic       nine_bit_mode = 1'b0;
  logic       addr_filter_en = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_bit9, rx_ready, rx_overrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam int BIT_CLK = 64;

  always #2.5 clk = ~clk;

  uart_vote_rx dut_i (
    .clk(clk), .rst(rst), .rxd_in(rxd_in), .tick_16x(tick_16x),
    .nine_bit_mode(nine_bit_mode), .addr_filter_en(addr_filter_en),
    .rd_strobe(rd_strobe), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
    .rx_ready(rx_ready), .rx_overrun(rx_overrun)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick_16x = 1'b1;
      @(negedge clk);
      tick_16x = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_accept(input bit nine, input bit filt, input logic [8:0] d, input bit stopv);
    return stopv && !(nine && filt && !d[8]);
  endfunction

  // gbit: frame bit index (0 = start) given a one-tick inversion at its centre, -1 none
  task automatic send_frame(input logic [8:0] d, input bit nine, input bit filt,
                            input int gbit, input bit stopv);
    int nb;
    logic v;
    nb = nine ? 9 : 8;
    @(negedge clk);
    nine_bit_mode  = nine;
    addr_filter_en = filt;
    for (int idx = 0; idx < nb + 2; idx++) begin
      if (idx == 0) v = 1'b0;
      else if (idx == nb + 1) v = stopv;
      else v = d[idx-1];
      for (int c = 0; c < BIT_CLK; c++) begin
        rxd_in = (idx == gbit && c >= 32 && c < 36) ? ~v : v;
        @(negedge clk);
      end
    end
    rxd_in = 1'b1;
  endtask

  task automatic idle_bits(input int n);
    repeat (n * BIT_CLK) @(negedge clk);
  endtask

  task automatic read_pulse();
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rx_ready == 1'b0, "R1 ready", rx_ready, 0);
    chk(rx_overrun == 1'b0, "R1 overrun", rx_overrun, 0);
    chk(rx_byte == 8'h00, "R1 byte", rx_byte, 0);
    chk(rx_bit9 == 1'b0, "R1 bit9", rx_bit9, 0);
    idle_bits(1);

    // R2 short frame
    send_frame(9'h0A5, 1'b0, 1'b0, -1, 1'b1);
    idle_bits(1);
    chk(rx_ready == 1'b1, "R2 ready", rx_ready, 1);
    chk(rx_byte == 8'hA5, "R2 byte", rx_byte, 8'hA5);
    chk(rx_bit9 == 1'b0, "R2 bit9", rx_bit9, 0);
    read_pulse();
    // R10 read clears
    chk(rx_ready == 1'b0, "R10 ready cleared", rx_ready, 0);

    // R3 long frame
    send_frame(9'h13C, 1'b1, 1'b0, -1, 1'b1);
    idle_bits(1);
    chk(rx_ready && rx_byte == 8'h3C, "R3 byte", rx_byte, 8'h3C);
    chk(rx_bit9 == 1'b1, "R3 bit9", rx_bit9, 1);
    read_pulse();

    // R4 glitch in data bit 3 (value 1 in 0x5A) and in start bit
    send_frame(9'h05A, 1'b0, 1'b0, 4, 1'b1);
    idle_bits(1);
    chk(rx_ready && rx_byte == 8'h5A, "R4 data glitch", rx_byte, 8'h5A);
    read_pulse();
    send_frame(9'h0C3, 1'b0, 1'b0, 0, 1'b1);
    idle_bits(1);
    chk(rx_ready && rx_byte == 8'hC3, "R4 start glitch", rx_byte, 8'hC3);
    read_pulse();

    // R5 false start: low for 4 ticks only
    @(negedge clk);
    rxd_in = 1'b0;
    repeat (16) @(negedge clk);
    rxd_in = 1'b1;
    idle_bits(2);
    chk(rx_ready == 1'b0, "R5 false start ignored", rx_ready, 0);
    chk(rx_byte == 8'hC3, "R5 byte unchanged", rx_byte, 8'hC3);
    send_frame(9'h071, 1'b0, 1'b0, -1, 1'b1);
    idle_bits(1);
    chk(rx_ready && rx_byte == 8'h71, "R5 next frame", rx_byte, 8'h71);
    read_pulse();

    // R6 stop low
    send_frame(9'h0EE, 1'b0, 1'b0, -1, 1'b0);
    idle_bits(2);
    chk(rx_ready == 1'b0, "R6 no ready", rx_ready, 0);
    chk(rx_byte == 8'h71, "R6 byte unchanged", rx_byte, 8'h71);

    // R7 address filter
    send_frame(9'h055, 1'b1, 1'b1, -1, 1'b1);
    idle_bits(1);
    chk(rx_ready == 1'b0, "R7 data frame dropped", rx_ready, 0);
    send_frame(9'h1AB, 1'b1, 1'b1, -1, 1'b1);
    idle_bits(1);
    chk(rx_ready && rx_byte == 8'hAB && rx_bit9, "R7 address accepted", rx_byte, 8'hAB);
    read_pulse();

    // R8 read during the next frame
    send_frame(9'h011, 1'b0, 1'b0, -1, 1'b1);
    idle_bits(1);
    fork
      send_frame(9'h022, 1'b0, 1'b0, -1, 1'b1);
      begin
        repeat (3 * BIT_CLK) @(negedge clk);
        chk(rx_ready && rx_byte == 8'h11, "R8 first held", rx_byte, 8'h11);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        chk(rx_ready == 1'b0, "R8 read mid-frame", rx_ready, 0);
      end
    join
    idle_bits(1);
    chk(rx_ready && rx_byte == 8'h22, "R8 second loaded", rx_byte, 8'h22);
    chk(rx_overrun == 1'b0, "R8 no overrun", rx_overrun, 0);

    // R9 overrun
    send_frame(9'h033, 1'b0, 1'b0, -1, 1'b1);
    idle_bits(1);
    chk(rx_overrun == 1'b1, "R9 overrun set", rx_overrun, 1);
    chk(rx_byte == 8'h22, "R9 old data kept", rx_byte, 8'h22);
    read_pulse();
    chk(!rx_ready && !rx_overrun, "R10 flags cleared", {rx_ready, rx_overrun}, 0);

    // random frames against bench model (R2 R3 R7)
    begin
      logic [7:0] last_b;
      last_b = rx_byte;
      for (int k = 0; k < 30; k++) begin
        logic [8:0] d;
        bit nine, filt, acc;
        d    = 9'($urandom);
        nine = 1'($urandom);
        filt = 1'($urandom);
        acc  = exp_accept(nine, filt, d, 1'b1);
        send_frame(d, nine, filt, -1, 1'b1);
        idle_bits(1);
        if (acc) begin
          last_b = d[7:0];
          chk(rx_ready && rx_byte == d[7:0] && rx_bit9 == (nine & d[8]),
              nine ? "R3 random" : "R2 random", {rx_bit9, rx_byte}, {nine & d[8], d[7:0]});
          read_pulse();
        end else begin
          chk(!rx_ready && rx_byte == last_b, "R7 random drop", rx_byte, last_b);
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule